// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the device-side engine that lets an external programmer load a chip's program memory and EEPROM over three wires while the chip is held in reset. It works only while the programming-mode input `prog_rst_n` is low. The programmer shifts 32-bit instructions into `sdi` and reads replies from `sdo`, with both timed by the programmer's serial clock `sck`. The block does not use `sck` as a clock. It synchronizes `sck` into the system clock domain and detects its edges there. Input bits are taken on rising edges. Output bits change on falling edges.

After programming mode is entered, the block accepts only the enable instruction. The reply to that instruction is an echo during its third byte. Once enabled, the block decodes reads and writes of the program memory (16-bit word address, low or high byte) and of the EEPROM (12-bit byte address). It also decodes a chip erase that sets both arrays to all ones. Write and erase operations make the block busy for a fixed number of system clocks, which models self-timed cell programming. Any instruction that completes during that window is dropped.

The memory arrays sit outside the block behind a plain synchronous strobe interface with one cycle of read latency. The serial edge has no flow control, so there is no valid/ready handshake. The programmer paces the block through the `sck` timing rules, and the arrays must accept a strobe in the cycle it is issued.

Top module: `isp_target`

## Requirements
- R1: The block acts only while `prog_rst_n` is low. While `prog_rst_n` is high, the enabled state, any partly received instruction and the busy timer are cleared, `sdo` is 0 and no memory strobe is issued. The next instruction after re-entry starts at bit 0.
- R2: `sdi` is sampled on each rising `sck` edge. `sdo` changes only after a falling `sck` edge, or when `prog_rst_n` is high. Each `sck` phase lasts at least 3 system clocks.
- R3: Each instruction is 4 bytes (32 bits) shifted in MSB first. Read data is returned MSB first on `sdo` during the fourth byte.
- R4: Enable is byte 1 = 0xAC and byte 2 = 0x53. The block returns 0x53 on `sdo` during byte 3 and becomes enabled when the fourth byte completes. Until then, every other instruction is ignored and returns 0x00.
- R5: Chip erase is byte 1 = 0xAC and byte 2 = 0x80. It pulses `erase_all`, after which every byte of both arrays reads 0xFF.
- R6: Program-memory reads use opcode 0x20 (low byte) or 0x28 (high byte). Writes use 0x40 (low) or 0x48 (high). Bytes 2–3 hold the word address, high byte first, and byte 4 of a write holds the data. `mem_hi` selects the byte.
- R7: EEPROM reads use opcode 0xA0 and writes use 0xC0, with the byte address in bytes 2–3. Address bits above bit 11 are ignored and are driven as 0 on `mem_addr`.
- R8: An EEPROM write replaces the target byte directly, with no erase needed first.
- R9: A write or erase raises `busy` for `BUSY_CYCLES` system clocks, starting in the same cycle as its strobe. An instruction that completes while `busy` is high has no effect.
- R10: An instruction with an unknown opcode changes no memory and returns 0x00. The next instruction is decoded normally.
- R11: `sdo` is 0 whenever no enable echo or read data is being shifted out, including during the fourth byte of writes.
- R12: At most one of `pm_we`, `pm_re`, `ee_we`, `ee_re`, `erase_all` is high in any cycle. Read data is taken from the array two cycles after the read strobe is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_rst_n | input | 1 | Chip reset pin, synchronous; low selects programming mode |
| sck | input | 1 | Serial clock from the programmer, asynchronous |
| sdi | input | 1 | Serial instruction input |
| sdo | output | 1 | Serial data output |
| busy | output | 1 | Self-timed write or erase in progress |
| mem_addr | output | 16 | Array address (EEPROM uses the low 12 bits) |
| mem_hi | output | 1 | Program-memory byte select, 1 = high byte |
| mem_wdata | output | 8 | Write data |
| pm_we | output | 1 | Program-memory write strobe |
| pm_re | output | 1 | Program-memory read strobe |
| pm_rdata | input | 8 | Program-memory read data, valid the cycle after `pm_re` |
| ee_we | output | 1 | EEPROM write strobe |
| ee_re | output | 1 | EEPROM read strobe |
| ee_rdata | input | 8 | EEPROM read data, valid the cycle after `ee_re` |
| erase_all | output | 1 | Chip erase strobe for both arrays |

## Verification
The assertions assume the following about the inputs:
- `prog_rst_n` is synchronous to `clk`.
- `sck` holds each level for at least three system clocks.
- `sdi` is already stable when `sck` rises.

Under those conditions, `sdo` can only move after a detected falling edge, and a write can only follow a cycle in which `busy` was low. The stimulus drives all inputs on the falling edge of `clk`. It changes `sdi` at the start of each low `sck` phase and holds every `sck` phase for six system clocks, which leaves margin for the synchronizer and the two-cycle read path.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_BITS = BYTE_W * WORD_BYTES;
  localparam int ADDR_W    = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_PREFIX   = 8'hAC;
  localparam logic [BYTE_W-1:0] SUB_ENABLE  = 8'h53;
  localparam logic [BYTE_W-1:0] SUB_ERASE   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_PM_RD_LO = 8'h20;
  localparam logic [BYTE_W-1:0] OP_PM_RD_HI = 8'h28;
  localparam logic [BYTE_W-1:0] OP_PM_WR_LO = 8'h40;
  localparam logic [BYTE_W-1:0] OP_PM_WR_HI = 8'h48;
  localparam logic [BYTE_W-1:0] OP_EE_RD    = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_EE_WR    = 8'hC0;

  typedef enum logic [2:0] {
    K_NONE, K_PM_RD, K_PM_WR, K_EE_RD, K_EE_WR, K_ERASE, K_ENABLE
  } isp_kind_e;

  function automatic isp_kind_e classify(input logic [BYTE_W-1:0] op,
                                         input logic [BYTE_W-1:0] sub);
    if (op == OP_PREFIX && sub == SUB_ENABLE) return K_ENABLE;
    if (op == OP_PREFIX && sub == SUB_ERASE)  return K_ERASE;
    if (op == OP_PM_RD_LO || op == OP_PM_RD_HI) return K_PM_RD;
    if (op == OP_PM_WR_LO || op == OP_PM_WR_HI) return K_PM_WR;
    if (op == OP_EE_RD) return K_EE_RD;
    if (op == OP_EE_WR) return K_EE_WR;
    return K_NONE;
  endfunction
endpackage

// File: rtl/isp_sck_sync.sv
module isp_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic sdi,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] sdi_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '0;
      sdi_pipe <= '0;
    end else begin
      sck_pipe <= {sck_pipe[STAGES-1:0], sck};
      sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi};
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign sdi_s    = sdi_pipe[STAGES-1];
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter
  import isp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  sck_rise,
  input  logic                  sck_fall,
  input  logic                  sdi_s,
  input  logic                  load,
  input  logic [BYTE_W-1:0]     load_byte,
  output logic [WORD_BITS-1:0]  word_nxt,
  output logic [WORD_BYTES-1:0] byte_done,
  output logic                  sdo
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [CNT_W-1:0]     cnt;
  logic [WORD_BITS-1:0] sh;
  logic [BYTE_W-1:0]    obuf;

  assign word_nxt = {sh[WORD_BITS-2:0], sdi_s};

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_done
    assign byte_done[g] = sck_rise && (cnt == CNT_W'((g + 1) * BYTE_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sh   <= '0;
      obuf <= '0;
      sdo  <= 1'b0;
    end else if (clear) begin
      cnt  <= '0;
      sh   <= '0;
      obuf <= '0;
      sdo  <= 1'b0;
    end else begin
      if (sck_rise) begin
        sh  <= word_nxt;
        cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
      end
      if (load) begin
        obuf <= load_byte;
      end else if (sck_fall) begin
        sdo  <= obuf[BYTE_W-1];
        obuf <= {obuf[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
  import isp_pkg::*;
#(
  parameter int EE_AW       = 12,
  parameter int BUSY_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [WORD_BYTES-1:0] byte_done,
  input  logic [WORD_BITS-1:0]  word,
  input  logic [BYTE_W-1:0]     pm_rdata,
  input  logic [BYTE_W-1:0]     ee_rdata,
  output logic                  load,
  output logic [BYTE_W-1:0]     load_byte,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_hi,
  output logic [BYTE_W-1:0]     mem_wdata,
  output logic                  pm_we,
  output logic                  pm_re,
  output logic                  ee_we,
  output logic                  ee_re,
  output logic                  erase_all,
  output logic                  busy
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] busy_cnt;
  logic enabled, echo_pend, rd_pend, rd_from_ee;
  logic idle, ready;

  // field views at each byte boundary (word holds the newest bit in bit 0)
  logic [BYTE_W-1:0] b2_op, b2_sub, b3_op, b4_op, b4_sub, b4_data;
  logic [ADDR_W-1:0] b3_addr, b4_addr;
  isp_kind_e k2, k3, k4;

  assign b2_op   = word[2*BYTE_W-1 -: BYTE_W];
  assign b2_sub  = word[BYTE_W-1:0];
  assign b3_op   = word[3*BYTE_W-1 -: BYTE_W];
  assign b3_addr = word[ADDR_W-1:0];
  assign b4_op   = word[4*BYTE_W-1 -: BYTE_W];
  assign b4_sub  = word[3*BYTE_W-1 -: BYTE_W];
  assign b4_addr = word[3*BYTE_W-1 -: ADDR_W];
  assign b4_data = word[BYTE_W-1:0];

  assign k2 = classify(b2_op, b2_sub);
  assign k3 = classify(b3_op, 8'h00);
  assign k4 = classify(b4_op, b4_sub);

  assign idle  = (busy_cnt == '0);
  assign ready = enabled && idle;
  assign busy  = !idle;

  function automatic logic [ADDR_W-1:0] ee_map(input logic [ADDR_W-1:0] a);
    return ADDR_W'(a[EE_AW-1:0]);
  endfunction

  assign load      = echo_pend | rd_pend;
  assign load_byte = rd_pend ? (rd_from_ee ? ee_rdata : pm_rdata) : SUB_ENABLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      enabled    <= 1'b0;
      echo_pend  <= 1'b0;
      rd_pend    <= 1'b0;
      rd_from_ee <= 1'b0;
      mem_addr   <= '0;
      mem_hi     <= 1'b0;
      mem_wdata  <= '0;
      pm_we      <= 1'b0;
      pm_re      <= 1'b0;
      ee_we      <= 1'b0;
      ee_re      <= 1'b0;
      erase_all  <= 1'b0;
    end else if (!active) begin
      busy_cnt   <= '0;
      enabled    <= 1'b0;
      echo_pend  <= 1'b0;
      rd_pend    <= 1'b0;
      rd_from_ee <= 1'b0;
      pm_we      <= 1'b0;
      pm_re      <= 1'b0;
      ee_we      <= 1'b0;
      ee_re      <= 1'b0;
      erase_all  <= 1'b0;
    end else begin
      pm_we      <= 1'b0;
      pm_re      <= 1'b0;
      ee_we      <= 1'b0;
      ee_re      <= 1'b0;
      erase_all  <= 1'b0;
      echo_pend  <= 1'b0;
      rd_pend    <= pm_re | ee_re;
      rd_from_ee <= ee_re;
      if (!idle) busy_cnt <= busy_cnt - BW'(1);

      // after byte 2: confirm an enable request
      if (byte_done[1] && idle && k2 == K_ENABLE) echo_pend <= 1'b1;

      // after byte 3: address is complete, start a read
      if (byte_done[2] && ready) begin
        if (k3 == K_PM_RD) begin
          pm_re    <= 1'b1;
          mem_addr <= b3_addr;
          mem_hi   <= (b3_op == OP_PM_RD_HI);
        end else if (k3 == K_EE_RD) begin
          ee_re    <= 1'b1;
          mem_addr <= ee_map(b3_addr);
          mem_hi   <= 1'b0;
        end
      end

      // after byte 4: commit enable, writes and erase
      if (byte_done[3] && idle) begin
        if (k4 == K_ENABLE) enabled <= 1'b1;
        if (enabled) begin
          unique case (k4)
            K_ERASE: begin
              erase_all <= 1'b1;
              busy_cnt  <= BW'(BUSY_CYCLES);
            end
            K_PM_WR: begin
              pm_we     <= 1'b1;
              mem_addr  <= b4_addr;
              mem_hi    <= (b4_op == OP_PM_WR_HI);
              mem_wdata <= b4_data;
              busy_cnt  <= BW'(BUSY_CYCLES);
            end
            K_EE_WR: begin
              ee_we     <= 1'b1;
              mem_addr  <= ee_map(b4_addr);
              mem_hi    <= 1'b0;
              mem_wdata <= b4_data;
              busy_cnt  <= BW'(BUSY_CYCLES);
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/isp_target.sv
module isp_target
  import isp_pkg::*;
#(
  parameter int EE_AW       = 12,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_rst_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_hi,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              pm_we,
  output logic              pm_re,
  input  logic [BYTE_W-1:0] pm_rdata,
  output logic              ee_we,
  output logic              ee_re,
  input  logic [BYTE_W-1:0] ee_rdata,
  output logic              erase_all
);
  logic sck_rise, sck_fall, sdi_s;
  logic active;
  logic load;
  logic [BYTE_W-1:0]     load_byte;
  logic [WORD_BITS-1:0]  word_nxt;
  logic [WORD_BYTES-1:0] byte_done;

  assign active = !prog_rst_n;

  isp_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (sck),
    .sdi      (sdi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdi_s    (sdi_s)
  );

  isp_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (!active),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .sdi_s     (sdi_s),
    .load      (load),
    .load_byte (load_byte),
    .word_nxt  (word_nxt),
    .byte_done (byte_done),
    .sdo       (sdo)
  );

  isp_ctrl #(.EE_AW(EE_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .byte_done (byte_done),
    .word      (word_nxt),
    .pm_rdata  (pm_rdata),
    .ee_rdata  (ee_rdata),
    .load      (load),
    .load_byte (load_byte),
    .mem_addr  (mem_addr),
    .mem_hi    (mem_hi),
    .mem_wdata (mem_wdata),
    .pm_we     (pm_we),
    .pm_re     (pm_re),
    .ee_we     (ee_we),
    .ee_re     (ee_re),
    .erase_all (erase_all),
    .busy      (busy)
  );
endmodule

// File: rtl/isp_target_chk.sv
module isp_target_chk #(
  parameter int EE_AW = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        prog_rst_n,
  input logic        sck_fall,
  input logic        sdo,
  input logic        busy,
  input logic [15:0] mem_addr,
  input logic        pm_we,
  input logic        pm_re,
  input logic        ee_we,
  input logic        ee_re,
  input logic        erase_all
);
  logic any_wr, any_strobe;
  assign any_wr     = pm_we | ee_we | erase_all;
  assign any_strobe = any_wr | pm_re | ee_re;

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pm_we, pm_re, ee_we, ee_re, erase_all}));

  // R9
  no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> !$past(busy));

  // R9
  write_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> busy);

  // R7
  ee_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_we || ee_re) |-> ((mem_addr >> EE_AW) == 16'd0));

  // R1
  idle_when_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_rst_n && $past(prog_rst_n)) |-> (!sdo && !busy && !any_strobe));

  // R2
  sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> ($past(sck_fall) || $past(prog_rst_n)));
endmodule

bind isp_target isp_target_chk #(.EE_AW(EE_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog_rst_n (prog_rst_n),
  .sck_fall   (sck_fall),
  .sdo        (sdo),
  .busy       (busy),
  .mem_addr   (mem_addr),
  .pm_we      (pm_we),
  .pm_re      (pm_re),
  .ee_we      (ee_we),
  .ee_re      (ee_re),
  .erase_all  (erase_all)
);

// File: tb/tb_isp_target.sv
module tb_isp_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int BUSY       = 500;
  localparam int NVEC       = 18;

  logic clk = 1'b0, rst_n = 1'b0, prog_rst_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, busy, mem_hi, pm_we, pm_re, ee_we, ee_re, erase_all;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, pm_rdata, ee_rdata;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_target #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .prog_rst_n(prog_rst_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .busy(busy), .mem_addr(mem_addr), .mem_hi(mem_hi),
    .mem_wdata(mem_wdata), .pm_we(pm_we), .pm_re(pm_re), .pm_rdata(pm_rdata),
    .ee_we(ee_we), .ee_re(ee_re), .ee_rdata(ee_rdata), .erase_all(erase_all)
  );

  // array model: absent entries read as erased (0xFF)
  logic [7:0] pm_mem [int];
  logic [7:0] ee_mem [int];
  initial begin pm_rdata = 8'h00; ee_rdata = 8'h00; end
  always @(posedge clk) begin
    if (erase_all) begin pm_mem.delete(); ee_mem.delete(); end
    if (pm_we) pm_mem[int'({mem_hi, mem_addr})] = mem_wdata;
    if (ee_we) ee_mem[int'(mem_addr)] = mem_wdata;
    if (pm_re) pm_rdata <= pm_mem.exists(int'({mem_hi, mem_addr})) ? pm_mem[int'({mem_hi, mem_addr})] : 8'hFF;
    if (ee_re) ee_rdata <= ee_mem.exists(int'(mem_addr)) ? ee_mem[int'(mem_addr)] : 8'hFF;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] w, input int nbits,
                      output logic [7:0] b3, output logic [7:0] b4);
    b3 = '0; b4 = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sdi = w[31-i];
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 24) b3[23-i] = sdo;
      if (i >= 24) b4[31-i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // {req[3:0], instruction[31:0], expected byte 4[7:0]}
  localparam logic [43:0] VECS [NVEC] = '{
    {4'd4,  32'h2000_3000, 8'hFF}, // R4 pre-enable write to 0x0030 was dropped
    {4'd11, 32'h4000_105A, 8'h00}, // R11 write returns zeros
    {4'd6,  32'h4800_10A5, 8'h00}, // R6 high byte write
    {4'd6,  32'h40FF_FF3C, 8'h00}, // R6 top address
    {4'd6,  32'h2000_1000, 8'h5A}, // R6
    {4'd6,  32'h2800_1000, 8'hA5}, // R6
    {4'd3,  32'h20FF_FF00, 8'h3C}, // R3
    {4'd6,  32'h28FF_FF00, 8'hFF}, // R6 high byte untouched
    {4'd7,  32'hC00F_FF77, 8'h00}, // R7
    {4'd7,  32'hA00F_FF00, 8'h77}, // R7
    {4'd7,  32'hC0F1_2311, 8'h00}, // R7 upper address bits set
    {4'd7,  32'hA001_2300, 8'h11}, // R7 aliases to 0x123
    {4'd8,  32'hC00F_FF88, 8'h00}, // R8 overwrite without erase
    {4'd8,  32'hA00F_FF00, 8'h88}, // R8
    {4'd10, 32'h5500_10EE, 8'h00}, // R10 unknown opcode
    {4'd10, 32'h2000_1000, 8'h5A}, // R10 next word aligned
    {4'd10, 32'h4100_10EE, 8'h00}, // R10 near-miss opcode
    {4'd10, 32'h2000_1000, 8'h5A}  // R10 memory unchanged
  };

  initial begin
    logic [7:0] b3, b4;
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset sdo", 32'(sdo), 32'h0);
    check("R1 reset busy", 32'(busy), 32'h0);
    prog_rst_n = 1'b0;
    repeat (4) @(negedge clk);

    // R4: nothing works before enable
    xfer(32'h2000_1000, 32, b3, b4);
    check("R4 read before enable", 32'(b4), 32'h00);
    xfer(32'h4000_3099, 32, b3, b4);
    check("R4 write before enable not busy", 32'(busy), 32'h0);

    xfer(32'hAC53_0000, 32, b3, b4);
    check("R4 enable echo", 32'(b3), 32'h53);
    check("R11 enable byte4", 32'(b4), 32'h00);

    for (int i = 0; i < NVEC; i++) begin
      xfer(VECS[i][39:8], 32, b3, b4);
      check($sformatf("R%0d vector %0d", VECS[i][43:40], i), 32'(b4), 32'(VECS[i][7:0]));
      wait_idle();
    end

    // R9: busy window and instructions dropped while busy
    xfer(32'h4000_2001, 32, b3, b4);
    check("R9 busy after write", 32'(busy), 32'h1);
    cnt = 0;
    while (busy) begin @(negedge clk); cnt++; end
    check("R9 busy length in range", 32'(cnt <= BUSY && cnt >= BUSY - 2*HALF - 10), 32'h1);
    xfer(32'h4000_2001, 32, b3, b4);
    xfer(32'h4000_2102, 32, b3, b4);
    wait_idle();
    xfer(32'h2000_2100, 32, b3, b4);
    check("R9 write during busy dropped", 32'(b4), 32'hFF);
    xfer(32'h2000_2000, 32, b3, b4);
    check("R9 earlier write kept", 32'(b4), 32'h01);

    // R5: chip erase
    xfer(32'hAC80_0000, 32, b3, b4);
    check("R5 erase busy", 32'(busy), 32'h1);
    wait_idle();
    xfer(32'h2000_1000, 32, b3, b4);
    check("R5 pm erased", 32'(b4), 32'hFF);
    xfer(32'hA00F_FF00, 32, b3, b4);
    check("R5 ee erased", 32'(b4), 32'hFF);

    // R1: abort mid-word, leave and re-enter programming mode
    xfer(32'hAC53_0000, 10, b3, b4);
    prog_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 released sdo", 32'(sdo), 32'h0);
    check("R1 released busy", 32'(busy), 32'h0);
    prog_rst_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer(32'h2800_1000, 32, b3, b4);
    check("R1 enable cleared", 32'(b4), 32'h00);
    xfer(32'hAC53_0000, 32, b3, b4);
    check("R1 realigned enable echo", 32'(b3), 32'h53);
    xfer(32'h2800_1000, 32, b3, b4);
    check("R2 read after re-enable", 32'(b4), 32'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule